// File: doc/BRIEF.md
# DMA Request Edge-Activation Front-End

This block sits in front of one channel of an external-bus DMA controller. It takes an active-low request pin from outside the chip and turns each falling edge into a one-cycle start request for the transfer engine. Edges are not found by comparing the pin with its previous value. A three-state handshake does the sensing instead. The handshake first waits for the pin to go low. It then waits until the engine reports that a transfer can start, and after that it waits for the pin to go high again. So one low phase of the pin can give at most one start.

The block also holds a small channel mode register with three bits: a transfer enable, a transfer-end flag and an interrupt enable. While the channel is enabled, the register is locked. The only write that takes effect is one that clears the enable bit, and clearing it shuts the request path down. The interrupt output is the transfer-end flag gated by the interrupt enable.

Top module: `dma_req_frontend`

## Requirements
- R1: During and after reset, the register reads back 000, and both start_req and irq are 0.
- R2: The request pin passes through a two-flop synchronizer. A level driven before clock edge k is first seen by the handshake at edge k+2.
- R3: In the armed state, a synchronized low level moves the handshake to the pending state. After the enable is set, the handshake arms on the second clock edge, so a pin that is already low starts the first transfer by level alone.
- R4: In the pending state, start_req is high for exactly the one cycle in which xfer_ok is high. The handshake then leaves the pending state.
- R5: After a start, no further start is issued until the synchronized pin has been high and then low again.
- R6: While the enable bit (bit 0) is 1, a write with bit 0 = 0 clears the enable. Every other effect of a write is ignored while the enable is 1: the interrupt enable (bit 2) does not change and the flag (bit 1) is not cleared.
- R7: While the enable is 0, start_req stays 0 whatever the pin and xfer_ok do, and the handshake returns to idle.
- R8: A pulse on xfer_done sets the flag (bit 1). When the enable is 0, writing 0 to bit 1 clears the flag and writing 1 to it has no effect. If xfer_done and a clearing write fall in the same cycle, the flag stays set.
- R9: irq is 1 exactly when the flag (bit 1) and the interrupt enable (bit 2) are both 1.
- R10: The register reads back as {interrupt enable, flag, enable} on bits 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 1 | Raw external request pin, active low |
| xfer_ok | input | 1 | Transfer engine can accept a start |
| xfer_done | input | 1 | One-cycle pulse at the end of a transfer |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Register write data |
| rd_data | output | 3 | Register read data |
| start_req | output | 1 | One-cycle transfer start request |
| irq | output | 1 | Transfer-end interrupt |

## Verification
Two events can fall in the same cycle and need checking. The first is a transfer-done pulse arriving in the same cycle as a software write that clears the flag. The bench drives both in one vector with the channel disabled, then reads the register back on the next cycle: the flag must still be set and irq must stay high. The second is a write that clears the enable while the channel is armed. The bench holds the pin low and xfer_ok high right after that write and expects no start. A further write with the clearing bit pattern, made while the channel runs, must leave the register unchanged.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int REG_W    = 3;
  localparam int BIT_EN   = 0;
  localparam int BIT_FLAG = 1;
  localparam int BIT_IEN  = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_PEND  = 2'd2,
    ST_BLOCK = 2'd3
  } act_st_t;

  // next state of the activation handshake
  function automatic act_st_t act_next(act_st_t cur, logic en, logic pin_lo, logic ok);
    act_st_t nx;
    nx = cur;
    if (!en) nx = ST_IDLE;
    else begin
      case (cur)
        ST_IDLE:  nx = ST_ARM;
        ST_ARM:   if (pin_lo) nx = ST_PEND;
        ST_PEND:  if (ok) nx = ST_BLOCK;
        ST_BLOCK: if (!pin_lo) nx = ST_ARM;
        default:  nx = ST_IDLE;
      endcase
    end
    return nx;
  endfunction

  function automatic logic start_of(act_st_t cur, logic en, logic ok);
    return en && ok && (cur == ST_PEND);
  endfunction

  function automatic logic irq_of(logic flag, logic ien);
    return flag & ien;
  endfunction
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_s
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], pin_n};
  end

  assign pin_s = sh[STAGES-1];
endmodule

// File: rtl/dreq_fsm.sv
module dreq_fsm
  import dreq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    pin_s,
  input  logic    xfer_ok,
  output act_st_t state,
  output logic    start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= act_next(state, en, !pin_s, xfer_ok);
  end

  assign start = start_of(state, en, xfer_ok);
endmodule

// File: rtl/dreq_modereg.sv
module dreq_modereg
  import dreq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             xfer_done,
  output logic             en,
  output logic             flag,
  output logic             ien
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      ien <= 1'b0;
    end else if (wr_en) begin
      if (en) begin
        if (!wr_data[BIT_EN]) en <= 1'b0;
      end else begin
        en  <= wr_data[BIT_EN];
        ien <= wr_data[BIT_IEN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    flag <= 1'b0;
    else if (xfer_done)                            flag <= 1'b1;
    else if (wr_en && !en && !wr_data[BIT_FLAG])   flag <= 1'b0;
  end
endmodule

// File: rtl/dma_req_frontend.sv
module dma_req_frontend
  import dreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_n,
  input  logic             xfer_ok,
  input  logic             xfer_done,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             start_req,
  output logic             irq
);
  logic    pin_s;
  logic    chan_en;
  logic    flag;
  logic    ien;
  act_st_t act_state;

  dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(req_n), .pin_s(pin_s)
  );

  dreq_modereg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .xfer_done(xfer_done), .en(chan_en), .flag(flag), .ien(ien)
  );

  dreq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(chan_en), .pin_s(pin_s),
    .xfer_ok(xfer_ok), .state(act_state), .start(start_req)
  );

  always_comb begin
    rd_data           = '0;
    rd_data[BIT_EN]   = chan_en;
    rd_data[BIT_FLAG] = flag;
    rd_data[BIT_IEN]  = ien;
  end

  assign irq = irq_of(flag, ien);
endmodule

// File: rtl/dreq_frontend_chk.sv
module dreq_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic irq,
  input logic chan_en,
  input logic flag,
  input logic ien,
  input logic xfer_done,
  input logic wr_en,
  input logic wr_en_bit
);
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !start_req);

  a_r7_off_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !start_req);

  a_r8_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> flag);

  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ien));

  a_r6_lock_ien: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && chan_en) |=> $stable(ien));

  a_r6_keep_en: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && chan_en && wr_en_bit) |=> chan_en);
endmodule

bind dma_req_frontend dreq_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .irq(irq),
  .chan_en(chan_en), .flag(flag), .ien(ien), .xfer_done(xfer_done),
  .wr_en(wr_en), .wr_en_bit(wr_data[0])
);

// File: tb/sim_dma_req_frontend.sv
module sim_dma_req_frontend;
  localparam int PERIOD = 10;
  localparam int NV = 27;
  // row: {req_n, xfer_ok, xfer_done, wr_en, wr_data[2:0], exp_start, exp_irq, exp_rd[2:0]}
  localparam logic [11:0] VEC [NV] = '{
    12'b1_0_0_1_101_0_0_000, // c0  enable, ien=1 (R10)
    12'b1_0_0_0_000_0_0_101, // c1  IDLE -> ARM
    12'b0_0_0_0_000_0_0_101, // c2  pin low, sync stage 1 (R2)
    12'b0_0_0_0_000_0_0_101, // c3  sync stage 2
    12'b0_0_0_0_000_0_0_101, // c4  ARM sees low -> PEND (R3)
    12'b0_0_0_0_000_0_0_101, // c5  PEND, engine busy
    12'b0_1_0_0_000_1_0_101, // c6  start (R4)
    12'b0_1_0_0_000_0_0_101, // c7  BLOCK, pin still low (R5)
    12'b1_0_0_0_000_0_0_101, // c8
    12'b1_0_0_0_000_0_0_101, // c9
    12'b1_0_0_0_000_0_0_101, // c10 BLOCK -> ARM
    12'b1_1_0_0_000_0_0_101, // c11 armed, pin high: no start (R5)
    12'b1_0_0_1_001_0_0_101, // c12 locked write tries ien=0 (R6)
    12'b1_0_1_0_000_0_0_101, // c13 done pulse (R8)
    12'b1_0_0_0_000_0_1_111, // c14 irq (R9)
    12'b1_0_0_1_101_0_1_111, // c15 locked flag clear ignored (R6)
    12'b1_0_0_1_000_0_1_111, // c16 clear enable (R6, R7)
    12'b0_1_0_0_000_0_1_110, // c17 disabled: no start (R7)
    12'b0_1_1_1_100_0_1_110, // c18 done + clear same cycle (R8)
    12'b0_1_0_1_100_0_1_110, // c19 clear flag (R8)
    12'b0_1_0_1_000_0_0_100, // c20 ien=0
    12'b0_0_0_1_001_0_0_000, // c21 re-enable with pin already low (R3)
    12'b0_0_0_0_000_0_0_001, // c22 IDLE -> ARM
    12'b0_0_0_0_000_0_0_001, // c23 ARM -> PEND by level
    12'b0_1_0_0_000_1_0_001, // c24 start (R3, R4)
    12'b0_1_1_0_000_0_0_001, // c25 done with ien=0
    12'b0_0_0_0_000_0_0_011  // c26 flag set, irq masked (R9)
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_n = 1'b1;
  logic       xfer_ok = 1'b0;
  logic       xfer_done = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_data = 3'b000;
  logic [2:0] rd_data;
  logic       start_req;
  logic       irq;
  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_req_frontend u0 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .xfer_ok(xfer_ok),
    .xfer_done(xfer_done), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .start_req(start_req), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 5000);
    bad++;
    total++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    #(PERIOD * 2 + 1);
    chk("R1 reset rd_data", int'(rd_data), 0);
    chk("R1 reset start_req", int'(start_req), 0);
    chk("R1 reset irq", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      if (i != 0) @(negedge clk);
      req_n     = v[11];
      xfer_ok   = v[10];
      xfer_done = v[9];
      wr_en     = v[8];
      wr_data   = v[7:5];
      #1;
      chk($sformatf("R4 start row %0d", i), int'(start_req), int'(v[4]));
      chk($sformatf("R9 irq row %0d", i), int'(irq), int'(v[3]));
      chk($sformatf("R10 rd_data row %0d", i), int'(rd_data), int'(v[2:0]));
    end
    // directed: reset in mid-operation clears everything (R1)
    @(negedge clk);
    req_n = 1'b1; xfer_ok = 1'b0; xfer_done = 1'b0; wr_en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset rd_data", int'(rd_data), 0);
    chk("R1 mid reset irq", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // directed: flag write of 1 while disabled has no effect (R8)
    wr_en = 1'b1; wr_data = 3'b010;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R8 write 1 to flag", int'(rd_data), 0);
    finish_run();
  end
endmodule